// File: doc/BRIEF.md
# Electrically erasable ROM mode controller

This block is a synthesizable behavioural model of a byte-wide nonvolatile memory together with the pin-level logic that selects its operating mode. On every clock it looks at the active-low chip enable and output enable, the address, and three condition flags. The flags mark a programming supply, an erase supply, and a high voltage on address bit 9. From these it picks one of several modes: read, output disable, standby, inhibit, program, program verify, erase, erase verify, or identifier read. It then drives or releases the data bus. The three-state drive is represented by a data-valid flag, `dout_en`. Analog levels and real pulse lengths are not modelled. A program or erase pulse on chip enable is accepted only if chip enable stays low for a parameterised minimum number of clock edges.

Programming can only clear bits: the new byte is the old byte ANDed with the data input. Erase is the only way back to ones, and it sets the whole array to 0xFF at once. The port carries a 15-bit address. The stored array depth is a parameter (`MEM_AW` bits, default 8, giving 256 bytes). Address bits at and above `MEM_AW` alias onto the stored bytes.

Top module: `eerom_ctrl`

## Requirements
- R1: With chip enable low, output enable low, neither supply flag and no high voltage on bit 9, one clock later `dout_en` is 1 and `dout` is the stored byte at addr[MEM_AW-1:0]; higher address bits are ignored.
- R2: With chip enable high and no verify condition (output enable high, or no supply flag), one clock later `dout_en` is 0.
- R3: With chip enable low and output enable high, one clock later `dout_en` is 0, whatever the supply flags.
- R4: A program pulse (programming supply only, output enable high, chip enable low for at least MIN_PULSE clock edges, default 4) stores old AND din at the address when chip enable rises.
- R5: A program or erase pulse with fewer than MIN_PULSE low clock edges leaves the array unchanged.
- R6: An erase pulse (erase supply, high voltage on bit 9, addr[0]=0, output enable high, chip enable low for at least MIN_PULSE edges) sets every byte to 0xFF when chip enable rises; with addr[0]=1 nothing is erased.
- R7: Chip enable high with output enable low while either supply flag is present (a verify mode) drives the stored byte at the address one clock later.
- R8: An identifier read (chip enable and output enable low, bit-9 high voltage, no supply flag) returns 0xDA for addr[0]=0 and 0x02 for addr[0]=1 one clock later.
- R9: With both supply flags present, the erase supply wins. An erase pulse erases, and a pulse without the bit-9 high voltage programs nothing.
- R10: After reset every byte reads 0xFF, and `dout_en` and `dout` are 0.
- R11: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 15 | Byte address |
| din | input | 8 | Program data |
| ce_n | input | 1 | Active-low chip enable / program-erase strobe |
| oe_n | input | 1 | Active-low output enable |
| vprog | input | 1 | Programming supply present |
| verase | input | 1 | Erase supply present |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| dout | output | 8 | Output data, 0 when not driven |
| dout_en | output | 1 | Output drive enable (stands in for three-state) |

## Verification
The bound checker watches the mode decode on every cycle. It checks that pin combinations releasing the bus clear `dout_en` one clock later, that read and verify combinations set it, that identifier reads return their fixed bytes, and that the data output is zero while released. Array changes are not visible to those properties. They are shown only by the bench's scenarios: AND-only programming, a pulse one clock too short, erase blocked by addr[0], supply priority, and address aliasing. Each scenario is followed by read-back through the normal read or verify modes.

// File: rtl/eerom_pkg.sv
package eerom_pkg;
   typedef enum logic [3:0] {
      MD_STANDBY,
      MD_INHIBIT,
      MD_READ,
      MD_OUT_OFF,
      MD_IDENT,
      MD_PROG,
      MD_PROG_VFY,
      MD_ERASE,
      MD_ERASE_VFY
   } eerom_mode_e;

   typedef enum logic [1:0] {
      WK_NONE,
      WK_PROG,
      WK_ERASE
   } eerom_work_e;
endpackage

// File: rtl/eerom_mode_decode.sv
module eerom_mode_decode
   import eerom_pkg::*;
(
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        vprog,
   input  logic        verase,
   input  logic        a9_hv,
   input  logic        a0,
   output eerom_mode_e mode,
   output eerom_work_e work,
   output logic        drive,
   output logic        ident
);
   always_comb begin
      if (ce_n) begin
         if (!oe_n && verase)      mode = MD_ERASE_VFY;
         else if (!oe_n && vprog)  mode = MD_PROG_VFY;
         else if (verase || vprog) mode = MD_INHIBIT;
         else                      mode = MD_STANDBY;
      end else if (verase) begin
         mode = (oe_n && a9_hv && !a0) ? MD_ERASE : MD_OUT_OFF;
      end else if (vprog) begin
         mode = oe_n ? MD_PROG : MD_OUT_OFF;
      end else if (!oe_n) begin
         mode = a9_hv ? MD_IDENT : MD_READ;
      end else begin
         mode = MD_OUT_OFF;
      end
   end

   always_comb begin
      case (mode)
         MD_PROG:  work = WK_PROG;
         MD_ERASE: work = WK_ERASE;
         default:  work = WK_NONE;
      endcase
   end

   assign drive = (mode == MD_READ) || (mode == MD_IDENT) ||
                  (mode == MD_PROG_VFY) || (mode == MD_ERASE_VFY);
   assign ident = (mode == MD_IDENT);
endmodule

// File: rtl/eerom_pulse_timer.sv
module eerom_pulse_timer
   import eerom_pkg::*;
#(
   parameter int MIN_PULSE = 4,
   parameter int MEM_AW    = 8,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  eerom_work_e       work,
   input  logic [MEM_AW-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              do_prog,
   output logic              do_erase,
   output logic [MEM_AW-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_data
);
   localparam int CNT_W = $clog2(MIN_PULSE + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

   logic             low_q;
   logic [CNT_W-1:0] cnt_q;
   eerom_work_e      work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q     <= 1'b0;
         cnt_q     <= '0;
         work_q    <= WK_NONE;
         hold_addr <= '0;
         hold_data <= '0;
      end else if (!ce_n) begin
         low_q     <= 1'b1;
         work_q    <= work;
         hold_addr <= addr;
         hold_data <= din;
         if (low_q && work == work_q) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= CNT_W'(1);
         end
      end else begin
         low_q <= 1'b0;
         cnt_q <= '0;
      end
   end

   logic ends_ok;
   assign ends_ok  = ce_n && low_q && (cnt_q == CNT_MAX);
   assign do_prog  = ends_ok && (work_q == WK_PROG);
   assign do_erase = ends_ok && (work_q == WK_ERASE);
endmodule

// File: rtl/eerom_array.sv
module eerom_array #(
   parameter int MEM_AW = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_prog,
   input  logic              do_erase,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q[i] <= '1;
         else if (do_erase)
            cell_q[i] <= '1;
         else if (do_prog && wr_addr == MEM_AW'(i))
            cell_q[i] <= cell_q[i] & wr_data;
      end
   end

   assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/eerom_ctrl.sv
module eerom_ctrl
   import eerom_pkg::*;
#(
   parameter int          ADDR_W    = 15,
   parameter int          MEM_AW    = 8,
   parameter int          DATA_W    = 8,
   parameter int          MIN_PULSE = 4,
   parameter logic [7:0]  MFR_ID    = 8'hDA,
   parameter logic [7:0]  DEV_ID    = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vprog,
   input  logic              verase,
   input  logic              a9_hv,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   if (ADDR_W < 10) begin : g_bad_addr
      $error("eerom_ctrl: ADDR_W must cover address bit 9");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("eerom_ctrl: MEM_AW must lie in 1..ADDR_W");
   end
   if (MIN_PULSE < 1) begin : g_bad_pulse
      $error("eerom_ctrl: MIN_PULSE must be at least 1");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("eerom_ctrl: identifier bytes need DATA_W of 8");
   end

   logic [MEM_AW-1:0] mem_addr;
   assign mem_addr = addr[MEM_AW-1:0];

   if (MEM_AW < ADDR_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:MEM_AW];
   end

   eerom_mode_e mode;
   eerom_work_e work;
   logic        drive;
   logic        ident;

   eerom_mode_decode u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vprog  (vprog),
      .verase (verase),
      .a9_hv  (a9_hv),
      .a0     (addr[0]),
      .mode   (mode),
      .work   (work),
      .drive  (drive),
      .ident  (ident)
   );

   logic              do_prog;
   logic              do_erase;
   logic [MEM_AW-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;

   eerom_pulse_timer #(
      .MIN_PULSE (MIN_PULSE),
      .MEM_AW    (MEM_AW),
      .DATA_W    (DATA_W)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .work      (work),
      .addr      (mem_addr),
      .din       (din),
      .do_prog   (do_prog),
      .do_erase  (do_erase),
      .hold_addr (hold_addr),
      .hold_data (hold_data)
   );

   logic [DATA_W-1:0] rd_data;

   eerom_array #(
      .MEM_AW (MEM_AW),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_prog  (do_prog),
      .do_erase (do_erase),
      .wr_addr  (hold_addr),
      .wr_data  (hold_data),
      .rd_addr  (mem_addr),
      .rd_data  (rd_data)
   );

   logic [DATA_W-1:0] out_sel;
   always_comb begin
      if (ident) out_sel = addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
      else       out_sel = rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_en <= 1'b0;
         dout    <= '0;
      end else begin
         dout_en <= drive;
         dout    <= drive ? out_sel : '0;
      end
   end
endmodule

// File: rtl/eerom_ctrl_chk.sv
module eerom_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ce_n,
   input logic              oe_n,
   input logic              vprog,
   input logic              verase,
   input logic              a9_hv,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);
   logic nosup;
   assign nosup = !vprog && !verase;

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && nosup && !a9_hv) |=> dout_en); // R1

   AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && (oe_n || nosup)) |=> !dout_en); // R2

   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |=> !dout_en); // R3

   AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && !oe_n && !nosup) |=> dout_en); // R7

   AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && nosup && a9_hv && !addr[0]) |=> (dout_en && dout == 8'hDA)); // R8

   AST_IDENT_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && nosup && a9_hv && addr[0]) |=> (dout_en && dout == 8'h02)); // R8

   AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0)); // R11
endmodule

bind eerom_ctrl eerom_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .ce_n    (ce_n),
   .oe_n    (oe_n),
   .vprog   (vprog),
   .verase  (verase),
   .a9_hv   (a9_hv),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/sim_eerom_ctrl.sv
module sim_eerom_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        vprog = 1'b0;
   logic        verase = 1'b0;
   logic        a9_hv = 1'b0;
   logic [7:0]  dout;
   logic        dout_en;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   eerom_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
      .oe_n(oe_n), .vprog(vprog), .verase(verase), .a9_hv(a9_hv),
      .dout(dout), .dout_en(dout_en)
   );

   // {ce_n, oe_n, vprog, verase, a9_hv, addr[14:0], din[7:0], exp_en, exp_dout[7:0]}
   localparam int NV = 9;
   localparam logic [36:0] VEC [NV] = '{
      {5'b00000, 15'h0005, 8'h00, 1'b1, 8'hFF},  // R1 read erased byte
      {5'b00001, 15'h0200, 8'h00, 1'b1, 8'hDA},  // R8 manufacturer id
      {5'b00001, 15'h0201, 8'h00, 1'b1, 8'h02},  // R8 device id
      {5'b10000, 15'h0005, 8'h00, 1'b0, 8'h00},  // R2 standby, R11
      {5'b11100, 15'h0005, 8'h00, 1'b0, 8'h00},  // R2 inhibit
      {5'b01000, 15'h0005, 8'h00, 1'b0, 8'h00},  // R3 output disable
      {5'b01010, 15'h0001, 8'h00, 1'b0, 8'h00},  // R3 erase setup, a0 high
      {5'b10100, 15'h0007, 8'h00, 1'b1, 8'hFF},  // R7 program verify
      {5'b10010, 15'h0007, 8'h00, 1'b1, 8'hFF}   // R7 erase verify
   };

   task automatic check(input string tag, input logic en_exp, input logic [7:0] d_exp);
      total++;
      if (dout_en !== en_exp || dout !== d_exp) begin
         bad++;
         $display("FAIL %s: en=%0b dout=%02h expected en=%0b dout=%02h",
                  tag, dout_en, dout, en_exp, d_exp);
      end
   endtask

   task automatic step(input logic c, input logic o, input logic vp, input logic ve,
                       input logic hv, input logic [14:0] a, input logic [7:0] d);
      ce_n = c; oe_n = o; vprog = vp; verase = ve; a9_hv = hv; addr = a; din = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [14:0] a, input logic [7:0] exp, input string tag);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
      check(tag, 1'b1, exp);
   endtask

   task automatic pulse(input int n, input logic [14:0] a, input logic [7:0] d,
                        input logic vp, input logic ve, input logic hv);
      ce_n = 1'b0; oe_n = 1'b1; vprog = vp; verase = ve; a9_hv = hv; addr = a; din = d;
      repeat (n) @(posedge clk);
      @(negedge clk);
      ce_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vprog = 1'b0; verase = 1'b0; a9_hv = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: en=%0b dout=%02h expected run to complete", dout_en, dout);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R10 reset outputs", 1'b0, 8'h00);
      rd(15'h0000, 8'hFF, "R10 reset contents");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32],
              VEC[i][31:17], VEC[i][16:9]);
         check($sformatf("vector %0d", i), VEC[i][8], VEC[i][7:0]);
      end

      pulse(4, 15'h0012, 8'h5A, 1'b1, 1'b0, 1'b0);
      rd(15'h0012, 8'h5A, "R4 first program");
      pulse(4, 15'h0012, 8'h0F, 1'b1, 1'b0, 1'b0);
      rd(15'h0012, 8'h0A, "R4 program ANDs");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 15'h0012, 8'h00);
      check("R7 program verify", 1'b1, 8'h0A);
      rd(15'h0112, 8'h0A, "R1 upper bits alias");

      pulse(3, 15'h0013, 8'h00, 1'b1, 1'b0, 1'b0);
      rd(15'h0013, 8'hFF, "R5 short program");

      pulse(4, 15'h0034, 8'h00, 1'b1, 1'b0, 1'b0);
      rd(15'h0034, 8'h00, "R4 program zero");
      pulse(5, 15'h0001, 8'h00, 1'b0, 1'b1, 1'b1);
      rd(15'h0012, 8'h0A, "R6 erase blocked by a0");

      pulse(4, 15'h0056, 8'h00, 1'b1, 1'b1, 1'b0);
      rd(15'h0056, 8'hFF, "R9 both supplies no program");
      pulse(3, 15'h0000, 8'h00, 1'b0, 1'b1, 1'b1);
      rd(15'h0034, 8'h00, "R5 short erase");
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 15'h0034, 8'h00);
      check("R7 erase verify before erase", 1'b1, 8'h00);

      pulse(4, 15'h0000, 8'h00, 1'b1, 1'b1, 1'b1);
      rd(15'h0012, 8'hFF, "R9 both supplies erase");
      rd(15'h0034, 8'hFF, "R6 erase all bytes");
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 15'h0012, 8'h00);
      check("R7 erase verify after erase", 1'b1, 8'hFF);

      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000, 8'h00);
      check("R11 idle zero", 1'b0, 8'h00);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule